// File: doc/BRIEF.md
# Chainable Serial Converter Code Loader

This block is the digital front end of a 16-bit current-loop converter. It takes a three-pin serial stream (bit clock, data and a load strobe) from a host. It assembles the stream into a shift register and hands a complete word to a held output code when the strobe rises. The serial pins are sampled into the system clock domain, and their rising edges are found there, so the host may toggle them at any rate well below the system clock.

The word leaving the top of the shift register appears on a serial output pin. Several loaders can therefore be wired in a string and filled from one stream before a shared strobe updates them all together. An asynchronous clear pulls the held code to the bottom of the span, which is code zero, at once. The code stays there until the next strobe. The assembled input word is not disturbed by the clear. A two-bit span selector is decoded into a one-hot span indication for the analog stage.

The serial pins carry no valid/ready handshake: the host owns the pace and there is no back-pressure. The bit clock must simply stay low and high for more than SYNC_STAGES+1 system clocks per phase.

Top module: `serial_dac_loader`

## Requirements
- R1: Each detected rising edge of `sclk_i` shifts exactly one bit of `sdi_i` into the shift register. Bits enter at the least significant end, so a word is sent most significant bit first and ends with bit 0.
- R2: A rising edge of `latch_i` with `clear_i` low copies the whole shift register into `code_o` in parallel.
- R3: Between rising edges of `latch_i`, `code_o` does not change, whatever `sclk_i` and `sdi_i` do, except when forced by clear.
- R4: `sdo_o` shows the bit held in the most significant position of the shift register and updates after every shift. After a full word A followed by k bits of a word B, `sdo_o` equals bit 15-k of A (k = 0..15).
- R5: While `clear_i` is high, `code_o` is 0x0000. This takes effect asynchronously, without waiting for a system clock edge.
- R6: A latch edge while `clear_i` is high leaves `code_o` at 0x0000. After `clear_i` falls, `code_o` stays 0x0000 until the next latch edge. That edge loads the word shifted in before the clear, because clear leaves the shift register unchanged.
- R7: After reset, `code_o` is 0x0000 and `sdo_o` is 0.
- R8: `span_oh_o` is one-hot, with the bit index equal to the value of `range_i`:
  - 00 gives bit 0, the 0–5 V span.
  - 01 gives bit 1, the 4–20 mA span.
  - 10 gives bit 2, the 0–20 mA span.
  - 11 gives bit 3, the 0–24 mA span.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| sclk_i | input | 1 | Serial bit clock, asynchronous to `clk` |
| sdi_i | input | 1 | Serial data in, sampled on the rising `sclk_i` edge |
| latch_i | input | 1 | Load strobe; a rising edge transfers the word |
| clear_i | input | 1 | Asynchronous clear to bottom of span, active high |
| range_i | input | 2 | Span selector |
| sdo_o | output | 1 | Serial data out for chaining |
| code_o | output | WORD_W | Held converter code |
| span_oh_o | output | 4 | One-hot decoded span |

## Verification
The bench builds the loader with its defaults: a 16-bit word and a two-flop synchronizer. With these values, full-word chaining is exercised over all sixteen bit positions, including the handover from the previous word to the new word's MSB. The bench holds each serial pin phase for several system clocks, well above the two-flop latency. This lets it sample after every single shift and observe the serial output bit by bit. With a 16-bit word, the all-ones and single-LSB patterns also probe both ends of the register.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [1:0] {
    SPAN_V0_5   = 2'b00,
    SPAN_I4_20  = 2'b01,
    SPAN_I0_20  = 2'b10,
    SPAN_I0_24  = 2'b11
  } span_e;

  localparam int SPAN_N = 4;

  function automatic logic [SPAN_N-1:0] span_decode(input logic [1:0] sel);
    span_e s;
    s = span_e'(sel);
    case (s)
      SPAN_V0_5:  return 4'b0001;
      SPAN_I4_20: return 4'b0010;
      SPAN_I0_20: return 4'b0100;
      default:    return 4'b1000;
    endcase
  endfunction
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdl_edge.sv
module sdl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/sdl_shift.sv
module sdl_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (shift_en_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign word_o = sr_q;
  assign msb_o  = sr_q[W-1];
endmodule

// File: rtl/sdl_hold.sv
module sdl_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] code_o
);
  logic         hold_rst_n;
  logic [W-1:0] code_q;

  assign hold_rst_n = rst_n & ~clear_i;

  always_ff @(posedge clk or negedge hold_rst_n) begin
    if (!hold_rst_n)  code_q <= '0;
    else if (load_i)  code_q <= word_i;
  end

  assign code_o = code_q;
endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              latch_i,
  input  logic              clear_i,
  input  logic [1:0]        range_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] code_o,
  output logic [3:0]        span_oh_o
);
  localparam int PIN_N   = 3;
  localparam int P_SCLK  = 0;
  localparam int P_SDI   = 1;
  localparam int P_LATCH = 2;

  logic [PIN_N-1:0]  pins_s;
  logic              sclk_rise;
  logic              latch_rise;
  logic [WORD_W-1:0] shift_word;

  sdl_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({latch_i, sdi_i, sclk_i}), .q_o(pins_s)
  );

  sdl_edge u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .level_i(pins_s[P_SCLK]), .rise_o(sclk_rise)
  );

  sdl_edge u_latch_edge (
    .clk(clk), .rst_n(rst_n), .level_i(pins_s[P_LATCH]), .rise_o(latch_rise)
  );

  sdl_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en_i(sclk_rise), .bit_i(pins_s[P_SDI]),
    .word_o(shift_word), .msb_o(sdo_o)
  );

  sdl_hold #(.W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_i(latch_rise),
    .word_i(shift_word), .code_o(code_o)
  );

  assign span_oh_o = sdl_pkg::span_decode(range_i);
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear_i,
  input logic         sdo_o,
  input logic [W-1:0] code_o,
  input logic [3:0]   span_oh_o,
  input logic         sclk_rise,
  input logic         latch_rise,
  input logic [W-1:0] shift_word
);
  p_clear_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> code_o == '0);

  p_latch_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && !clear_i) |=> (code_o == $past(shift_word)) || clear_i);

  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_rise |=> $stable(code_o) || clear_i || code_o == '0);

  p_sdo_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sdo_o == $past(shift_word[W-2]));

  p_span_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(span_oh_o) == 1);
endmodule

bind serial_dac_loader sdl_checker #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .sdo_o(sdo_o),
  .code_o(code_o), .span_oh_o(span_oh_o), .sclk_rise(sclk_rise),
  .latch_rise(latch_rise), .shift_word(shift_word)
);

// File: tb/sim_serial_dac_loader.sv
module sim_serial_dac_loader;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0, sdi = 1'b0, latch = 1'b0, clear = 1'b0;
  logic [1:0]   range = 2'b00;
  logic         sdo;
  logic [W-1:0] code;
  logic [3:0]   span_oh;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_dac_loader #(.WORD_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .latch_i(latch),
    .clear_i(clear), .range_i(range), .sdo_o(sdo), .code_o(code),
    .span_oh_o(span_oh)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) sdi = b;
    idle(2);
    sclk = 1'b1;
    idle(5);
    sclk = 1'b0;
    idle(5);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = W-1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_latch();
    @(negedge clk) latch = 1'b1;
    idle(5);
    latch = 1'b0;
    idle(5);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    check(code == 16'h0000, "R7 code after reset", code, 0);
    check(sdo == 1'b0, "R7 sdo after reset", sdo, 0);
  endtask

  task automatic t_load();
    send_word(16'hA5C3);
    check(code == 16'h0000, "R3 code before latch", code, 0);
    pulse_latch();
    check(code == 16'hA5C3, "R1 R2 load A5C3", code, 16'hA5C3);
    send_word(16'h0001);
    pulse_latch();
    check(code == 16'h0001, "R1 R2 load 0001", code, 16'h0001);
    send_word(16'hFFFF);
    pulse_latch();
    check(code == 16'hFFFF, "R1 R2 load FFFF", code, 16'hFFFF);
  endtask

  task automatic t_hold();
    send_word(16'h1234);
    check(code == 16'hFFFF, "R3 hold during shifting", code, 16'hFFFF);
  endtask

  task automatic t_chain();
    logic [W-1:0] a = 16'h9B2E;
    logic [W-1:0] b = 16'h6D71;
    send_word(a);
    check(sdo == a[W-1], "R4 sdo after word A", sdo, a[W-1]);
    for (int k = 0; k < W; k++) begin
      send_bit(b[W-1-k]);
      if (k < W-1)
        check(sdo == a[W-2-k], "R4 sdo forwards previous word", sdo, a[W-2-k]);
      else
        check(sdo == b[W-1], "R4 sdo new word msb", sdo, b[W-1]);
    end
  endtask

  task automatic t_clear();
    send_word(16'h5A5A);
    pulse_latch();
    check(code == 16'h5A5A, "R2 load before clear", code, 16'h5A5A);
    send_word(16'hC0DE);
    @(negedge clk) clear = 1'b1;
    #1;
    check(code == 16'h0000, "R5 async clear", code, 0);
    pulse_latch();
    check(code == 16'h0000, "R6 latch ignored during clear", code, 0);
    @(negedge clk) clear = 1'b0;
    idle(8);
    check(code == 16'h0000, "R6 stays bottom after clear", code, 0);
    pulse_latch();
    check(code == 16'hC0DE, "R6 input word kept through clear", code, 16'hC0DE);
  endtask

  task automatic t_range();
    for (int s = 0; s < 4; s++) begin
      @(negedge clk) range = s[1:0];
      #1;
      check(span_oh == (4'b0001 << s), "R8 span decode", span_oh, 4'b0001 << s);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    report();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_load();
    t_hold();
    t_chain();
    t_clear();
    t_range();
    report();
  end
endmodule